// File: doc/BRIEF.md
# Peer Setup Message Sequencer

This block reads a one-way stream of 64-bit signed messages, each tagged with a bit that says whether a resource handle travelled with it. It uses the stream to build the local interrupt wiring state: the local ID, whether shared memory is usable, how many send vectors each known peer has, and how many receive vectors the local side holds. What a message means depends on where it falls in the stream. The block enforces the order of the opening exchange and then applies connect and disconnect notices to a small peer table.

Messages arrive over a valid/ready handshake. Any ordering or range violation closes the session. After that the block stops accepting messages and freezes its state. A combinational query port looks up any peer ID in the table and returns whether it is present and how many vectors it has. Both the number of table slots and the number of locally configured vectors are parameters.

Top module: `peerSetupSeq`

## Requirements
- R1: After reset, msgReady is 1 and ownIdValid, shmReady, setupDone, sessionClosed and rxVecs are all 0. The query port reports no hit for any ID.
- R2: The first accepted message must be the version number 0. Any other value closes the session.
- R3: The second message is the local ID. It is accepted only if bits 63:16 are all zero, in which case bits 15:0 appear on ownId and ownIdValid goes to 1. Any other value closes the session.
- R4: The third message must be all ones (-1) with the handle bit set, which sets shmReady. Any other value, or a missing handle, closes the session.
- R5: In the opening peer phase, each message with a handle whose ID differs from the local ID adds one vector to that peer. The first such message creates the peer's entry with a count of 1.
- R6: A message carrying the local ID with a handle adds one receive vector. rxVecs and every peer count saturate at NUM_VECS (default 4), and any extra vectors are dropped.
- R7: setupDone stays 0 while local-ID messages are arriving. It goes to 1 on the first later message that is not a local-ID message with a handle, and that message is processed as an ongoing notice.
- R8: After setup, a peer ID with a handle is a connect notice: it adds a vector to a known peer or creates a new entry.
- R9: After setup, a peer ID without a handle is a disconnect notice: the matching entry is cleared. A disconnect for an unknown ID changes nothing and does not close the session.
- R10: A connect for an unknown peer while all PEER_SLOTS (default 4) entries are in use closes the session.
- R11: Several further cases close the session: a message without a handle before setup completes, a local-ID message after setup, and an ID with nonzero bits 63:16 in any ID phase. Once closed, sessionClosed and msgReady=0 hold until reset and no state changes.
- R12: The query port reports, without a clock, whether queryId is in the table, and returns its vector count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgValid | input | 1 | Message present |
| msgReady | output | 1 | Message accepted when high with msgValid |
| msgData | input | 64 | Signed message value |
| msgHasHandle | input | 1 | A handle accompanies the message |
| ownId | output | 16 | Local ID |
| ownIdValid | output | 1 | Local ID has been received |
| shmReady | output | 1 | Shared memory available |
| rxVecs | output | VEC_W | Connected receive vectors |
| setupDone | output | 1 | Interrupt setup complete (level) |
| sessionClosed | output | 1 | Protocol error seen, session closed |
| queryId | input | 16 | Peer ID to look up |
| queryHit | output | 1 | queryId present in table |
| queryVecs | output | VEC_W | Vector count of queried peer |

## Verification
The assertions assume the peer table never holds two valid entries with the same ID. This can only hold if allocation always looks up the incoming ID first, so the stimulus deliberately repeats peer IDs to exercise that path. The assertions also assume msgData and msgHasHandle are stable while msgValid is high. The bench drives both only at falling edges and deasserts valid right after each accepting edge. Messages are sent in sequences that are legal up to a single chosen violation, so each error check fires at a known message.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [2:0] {
    PH_VERSION, PH_OWNID, PH_SHM, PH_PEERS, PH_SETUP, PH_RUN, PH_CLOSED
  } phase_t;

  typedef struct packed {
    logic setOwn;
    logic setShm;
    logic addRx;
    logic peerAdd;
    logic peerDrop;
  } strobes_t;
endpackage

// File: rtl/pssPeerTable.sv
module pssPeerTable
  import pss_pkg::*;
#(
  parameter int PEER_SLOTS = 4,
  parameter int NUM_VECS   = 4,
  localparam int VEC_W     = $clog2(NUM_VECS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  input  logic [15:0]      msgId,
  input  logic [15:0]      queryId,
  output logic [15:0]      ownId,
  output logic             ownIdValid,
  output logic             shmReady,
  output logic [VEC_W-1:0] rxVecs,
  output logic             msgIsOwn,
  output logic             msgHit,
  output logic             tableFull,
  output logic             queryHit,
  output logic [VEC_W-1:0] queryVecs
);
  localparam logic [VEC_W-1:0] VEC_MAX = VEC_W'(NUM_VECS);

  logic [15:0]      slotId    [PEER_SLOTS];
  logic [VEC_W-1:0] slotVecs  [PEER_SLOTS];
  logic [PEER_SLOTS-1:0] slotValid;
  logic [PEER_SLOTS-1:0] matchVec;
  logic [PEER_SLOTS-1:0] freeOneHot;

  genvar g;
  generate
    for (g = 0; g < PEER_SLOTS; g++) begin : gMatch
      assign matchVec[g] = slotValid[g] && (slotId[g] == msgId);
    end
  endgenerate

  always_comb begin
    freeOneHot = '0;
    for (int i = PEER_SLOTS - 1; i >= 0; i--) begin
      if (!slotValid[i]) freeOneHot = PEER_SLOTS'(1) << i;
    end
  end

  assign msgHit    = |matchVec;
  assign tableFull = &slotValid;
  assign msgIsOwn  = ownIdValid && (msgId == ownId);

  always_comb begin
    queryHit  = 1'b0;
    queryVecs = '0;
    for (int i = 0; i < PEER_SLOTS; i++) begin
      if (slotValid[i] && slotId[i] == queryId) begin
        queryHit  = 1'b1;
        queryVecs = slotVecs[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownId      <= '0;
      ownIdValid <= 1'b0;
      shmReady   <= 1'b0;
      rxVecs     <= '0;
    end else begin
      if (strobes.setOwn) begin
        ownId      <= msgId;
        ownIdValid <= 1'b1;
      end
      if (strobes.setShm) shmReady <= 1'b1;
      if (strobes.addRx && rxVecs < VEC_MAX) rxVecs <= rxVecs + 1'b1;
    end
  end

  generate
    for (g = 0; g < PEER_SLOTS; g++) begin : gSlot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          slotValid[g] <= 1'b0;
          slotId[g]    <= '0;
          slotVecs[g]  <= '0;
        end else if (strobes.peerAdd) begin
          if (matchVec[g]) begin
            if (slotVecs[g] < VEC_MAX) slotVecs[g] <= slotVecs[g] + 1'b1;
          end else if (!msgHit && freeOneHot[g]) begin
            slotValid[g] <= 1'b1;
            slotId[g]    <= msgId;
            slotVecs[g]  <= VEC_W'(1);
          end
        end else if (strobes.peerDrop && matchVec[g]) begin
          slotValid[g] <= 1'b0;
          slotVecs[g]  <= '0;
        end
      end
    end
  endgenerate

  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rxVecs <= VEC_MAX); // R6
  AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec)); // R8
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.peerDrop |=> !msgHit || !$stable(msgId)); // R9
endmodule

// File: rtl/pssCtrl.sv
module pssCtrl
  import pss_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        msgValid,
  output logic        msgReady,
  input  logic [63:0] msgData,
  input  logic        msgHasHandle,
  input  logic        msgIsOwn,
  input  logic        msgHit,
  input  logic        tableFull,
  output strobes_t    strobes,
  output logic        setupDone,
  output logic        sessionClosed
);
  phase_t phase, phaseNext;
  logic   fire, inRange, fault, runMsg, doneSet;

  assign msgReady      = (phase != PH_CLOSED);
  assign sessionClosed = (phase == PH_CLOSED);
  assign fire          = msgValid && msgReady;
  assign inRange       = (msgData[63:16] == '0);

  always_comb begin
    phaseNext = phase;
    strobes   = '0;
    fault     = 1'b0;
    runMsg    = 1'b0;
    doneSet   = 1'b0;
    if (fire) begin
      unique case (phase)
        PH_VERSION: if (msgData == '0) phaseNext = PH_OWNID; else fault = 1'b1;
        PH_OWNID: begin
          if (inRange) begin
            strobes.setOwn = 1'b1;
            phaseNext      = PH_SHM;
          end else fault = 1'b1;
        end
        PH_SHM: begin
          if (msgHasHandle && (&msgData)) begin
            strobes.setShm = 1'b1;
            phaseNext      = PH_PEERS;
          end else fault = 1'b1;
        end
        PH_PEERS: begin
          if (!msgHasHandle || !inRange) fault = 1'b1;
          else if (msgIsOwn) begin
            strobes.addRx = 1'b1;
            phaseNext     = PH_SETUP;
          end else if (!msgHit && tableFull) fault = 1'b1;
          else strobes.peerAdd = 1'b1;
        end
        PH_SETUP: begin
          if (msgHasHandle && inRange && msgIsOwn) strobes.addRx = 1'b1;
          else begin
            doneSet   = 1'b1;
            phaseNext = PH_RUN;
            runMsg    = 1'b1;
          end
        end
        PH_RUN:   runMsg = 1'b1;
        default:  ;
      endcase
      if (runMsg) begin
        if (!inRange || msgIsOwn) fault = 1'b1;
        else if (msgHasHandle) begin
          if (!msgHit && tableFull) fault = 1'b1;
          else strobes.peerAdd = 1'b1;
        end else strobes.peerDrop = msgHit;
      end
      if (fault) begin
        strobes   = '0;
        phaseNext = PH_CLOSED;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_VERSION;
      setupDone <= 1'b0;
    end else begin
      phase <= phaseNext;
      if (doneSet) setupDone <= 1'b1;
    end
  end

  AST_CLOSED_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    sessionClosed |=> sessionClosed && !msgReady); // R11
  AST_QUIET_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    sessionClosed |-> strobes == '0); // R11
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    setupDone |=> setupDone); // R7
endmodule

// File: rtl/peerSetupSeq.sv
module peerSetupSeq
  import pss_pkg::*;
#(
  parameter int PEER_SLOTS = 4,
  parameter int NUM_VECS   = 4,
  localparam int VEC_W     = $clog2(NUM_VECS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgValid,
  output logic             msgReady,
  input  logic [63:0]      msgData,
  input  logic             msgHasHandle,
  output logic [15:0]      ownId,
  output logic             ownIdValid,
  output logic             shmReady,
  output logic [VEC_W-1:0] rxVecs,
  output logic             setupDone,
  output logic             sessionClosed,
  input  logic [15:0]      queryId,
  output logic             queryHit,
  output logic [VEC_W-1:0] queryVecs
);
  strobes_t strobes;
  logic     msgIsOwn, msgHit, tableFull;

  pssCtrl ctrl_i (
    .clk, .rstN, .msgValid, .msgReady, .msgData, .msgHasHandle,
    .msgIsOwn, .msgHit, .tableFull, .strobes, .setupDone, .sessionClosed
  );

  pssPeerTable #(.PEER_SLOTS(PEER_SLOTS), .NUM_VECS(NUM_VECS)) table_i (
    .clk, .rstN, .strobes, .msgId(msgData[15:0]), .queryId,
    .ownId, .ownIdValid, .shmReady, .rxVecs, .msgIsOwn, .msgHit,
    .tableFull, .queryHit, .queryVecs
  );

  AST_DONE_AFTER_SHM: assert property (@(posedge clk) disable iff (!rstN)
    setupDone |-> shmReady && ownIdValid && rxVecs != '0); // R7
  AST_SHM_AFTER_ID: assert property (@(posedge clk) disable iff (!rstN)
    shmReady |-> ownIdValid); // R4
endmodule

// File: tb/peerSetupSeq_tb_top.sv
module peerSetupSeq_tb_top;
  localparam int VEC_W = 3;
  localparam logic [63:0] NEG1 = '1;

  logic clk = 0, rstN = 0;
  logic msgValid = 0, msgHasHandle = 0;
  logic [63:0] msgData = '0;
  logic [15:0] queryId = '0;
  logic msgReady, ownIdValid, shmReady, setupDone, sessionClosed, queryHit;
  logic [15:0] ownId;
  logic [VEC_W-1:0] rxVecs, queryVecs;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  peerSetupSeq dut_i (
    .clk, .rstN, .msgValid, .msgReady, .msgData, .msgHasHandle,
    .ownId, .ownIdValid, .shmReady, .rxVecs, .setupDone, .sessionClosed,
    .queryId, .queryHit, .queryVecs
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; msgValid = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
  endtask

  task automatic send(input logic [63:0] d, input logic h);
    @(negedge clk); msgValid = 1; msgData = d; msgHasHandle = h;
    @(posedge clk); #1; msgValid = 0;
  endtask

  task automatic look(input logic [15:0] id, output logic hit, output logic [VEC_W-1:0] n);
    queryId = id; #1; hit = queryHit; n = queryVecs;
  endtask

  task automatic prelude(input logic [15:0] own);
    send(64'd0, 0); send({48'd0, own}, 0); send(NEG1, 1);
  endtask

  task automatic tResetState();
    logic h; logic [VEC_W-1:0] n;
    doReset();
    chk("R1 ready", msgReady, 1); chk("R1 idValid", ownIdValid, 0);
    chk("R1 shm", shmReady, 0); chk("R1 done", setupDone, 0);
    chk("R1 closed", sessionClosed, 0); chk("R1 rx", rxVecs, 0);
    look(16'd0, h, n); chk("R1 R12 query", h, 0);
  endtask

  task automatic tBadVersion();
    doReset(); send(64'd1, 0);
    chk("R2 bad version closes", sessionClosed, 1);
    chk("R11 ready low", msgReady, 0);
    send(64'd5, 0);
    chk("R11 frozen id", ownIdValid, 0);
  endtask

  task automatic tBadOwnId();
    doReset(); send(64'd0, 0);
    chk("R2 version ok", sessionClosed, 0);
    send(64'h1_0000, 0);
    chk("R3 range closes", sessionClosed, 1);
    doReset(); send(64'd0, 0); send(64'hFFFF, 0);
    chk("R3 id", ownId, 16'hFFFF); chk("R3 valid", ownIdValid, 1);
  endtask

  task automatic tBadShm();
    doReset(); send(64'd0, 0); send(64'd2, 0); send(64'd7, 1);
    chk("R4 not -1 closes", sessionClosed, 1);
    doReset(); send(64'd0, 0); send(64'd2, 0); send(NEG1, 0);
    chk("R4 no handle closes", sessionClosed, 1);
    chk("R4 shm stays 0", shmReady, 0);
  endtask

  task automatic tMainFlow();
    logic h; logic [VEC_W-1:0] n;
    doReset(); prelude(16'd5);
    chk("R4 shm set", shmReady, 1);
    send(64'd3, 1); send(64'd3, 1); send(64'd7, 1);
    look(16'd3, h, n); chk("R5 peer3 hit", h, 1); chk("R5 peer3 vecs", n, 2);
    look(16'd7, h, n); chk("R5 peer7 vecs", n, 1);
    for (int i = 0; i < 5; i++) send(64'd5, 1);
    chk("R6 rx saturates", rxVecs, 4);
    chk("R7 not done during own ids", setupDone, 0);
    send(64'd3, 0);
    chk("R7 done", setupDone, 1);
    look(16'd3, h, n); chk("R7 R9 first msg is disconnect", h, 0);
    send(64'd9, 1);
    look(16'd9, h, n); chk("R8 new peer", n, 1);
    send(64'd20, 0);
    chk("R9 unknown ignored", sessionClosed, 0);
    look(16'd9, h, n); chk("R9 others intact", n, 1);
    for (int i = 0; i < 5; i++) send(64'd7, 1);
    look(16'd7, h, n); chk("R6 R8 peer saturates", n, 4);
  endtask

  task automatic tTableFull();
    doReset(); prelude(16'd0);
    for (int i = 1; i <= 4; i++) send(64'(i), 1);
    send(64'd0, 1);
    send(64'd2, 1);
    chk("R8 known peer ok when full", sessionClosed, 0);
    send(64'd6, 1);
    chk("R10 full closes", sessionClosed, 1);
  endtask

  task automatic tOtherErrors();
    doReset(); prelude(16'd4); send(64'd8, 0);
    chk("R11 no handle before setup", sessionClosed, 1);
    doReset(); prelude(16'd4); send(64'd4, 1); send(64'd8, 1);
    chk("R11 legal run", sessionClosed, 0);
    send(64'd4, 1);
    chk("R11 own id after setup", sessionClosed, 1);
    doReset(); prelude(16'd4); send(64'd4, 1); send(64'h2_0001, 1);
    chk("R11 range after setup", sessionClosed, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tResetState();
    tBadVersion();
    tBadOwnId();
    tBadShm();
    tMainFlow();
    tTableFull();
    tOtherErrors();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule